// File: doc/BRIEF.md
# IN Endpoint Multi-Bank Transmit Buffer

This block holds outgoing packets for one device-side IN endpoint. Its buffer is cut into one to three equal banks. Software fills the current bank one byte at a time through a write port, then marks the bank ready to send. The serial engine on the other side reads a ready bank by byte index and reports whether the host acknowledged the packet. Banks are used strictly in turn: a fill pointer and a drain pointer each step through the banks and wrap to bank 0 after the last one.

A hardware auto-validate option lets software stream several packets without marking each one. With this option on, writing the last byte of a bank marks that bank ready and moves the fill pointer to the next bank. A short final packet still has to be marked by software. Each bank keeps its own byte count, so packets shorter than a bank are sent with the right length, and so are packets of length zero. An isochronous mode turns off auto-validate and keeps both pointers fixed on one bank. Two level interrupts, each with its own enable, report that the current bank can be written and that every bank has drained.

Top module: `inep_txbuf`

## Requirements
- R1: After reset, all banks are empty and hold zero bytes, both pointers are on bank 0, `busy_banks` is 0, auto-validate is off and both interrupt enables are off.
- R2: A write on `cpu_wr_en` stores one byte at the next free position of the current fill bank. The write is ignored if that bank is ready, if it already holds `BANK_BYTES` bytes, or if `sw_validate` is high in the same cycle.
- R3: `sw_validate` marks the current fill bank ready, with the number of bytes written into it, and moves the fill pointer on. Validating a bank that holds no bytes queues a packet of length 0. `sw_validate` is ignored while the current fill bank is already ready.
- R4: When auto-validate is on and isochronous mode is off, the write that brings a bank to `BANK_BYTES` bytes also marks that bank ready with length `BANK_BYTES`. The next write goes to the next bank.
- R5: When auto-validate is on and a bank holds fewer than `BANK_BYTES` bytes, that bank stays not ready until `sw_validate`.
- R6: `busy_banks` equals the number of banks that are ready and not yet acknowledged. It never exceeds `NUM_BANKS`. `cur_bank_ready` is high exactly when the current fill bank is ready.
- R7: When `usb_pkt_avail` is high, `usb_pkt_len` gives the byte count of the drain bank and `usb_rd_data` gives the byte at offset `usb_rd_idx`. A `usb_done` pulse with `usb_acked` high empties that bank and moves the drain pointer on. A `usb_done` pulse with `usb_acked` low leaves the bank ready and unchanged, so it can be sent again.
- R8: Packets reach the drain side in the same order in which they were validated, over any number of pointer wraps.
- R9: `auto_set` and `auto_clr` turn auto-validate on and off. `ien_set` and `ien_clr` set and clear interrupt enables. Bit 0 enables the free-bank interrupt and bit 1 enables the drained interrupt. If set and clear of the same bit come in the same cycle, the clear wins. `irq_free` is high when bit 0 is enabled and the current fill bank is not ready.
- R10: `irq_drained` is high when bit 1 is enabled and `busy_banks` is 0.
- R11: While `iso_mode` is high, auto-validate has no effect and neither pointer advances. A single bank is then filled, validated and drained again and again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | Write one byte into the current fill bank |
| cpu_wr_data | input | DATA_W | Byte to write |
| sw_validate | input | 1 | Mark the current fill bank ready |
| auto_set | input | 1 | Turn auto-validate on |
| auto_clr | input | 1 | Turn auto-validate off |
| ien_set | input | 2 | Interrupt enable set bits (0 free, 1 drained) |
| ien_clr | input | 2 | Interrupt enable clear bits |
| iso_mode | input | 1 | Isochronous endpoint configuration |
| usb_rd_idx | input | clog2(BANK_BYTES) | Byte offset read from the drain bank |
| usb_done | input | 1 | Transfer attempt of the drain bank finished |
| usb_acked | input | 1 | That attempt was acknowledged |
| cur_bank_ready | output | 1 | Current fill bank is ready |
| busy_banks | output | clog2(NUM_BANKS+1) | Count of ready banks |
| auto_en | output | 1 | Auto-validate state |
| ien | output | 2 | Interrupt enable state |
| usb_pkt_avail | output | 1 | Drain bank is ready |
| usb_pkt_len | output | clog2(BANK_BYTES+1) | Byte count of the drain bank |
| usb_rd_data | output | DATA_W | Byte at usb_rd_idx of the drain bank |
| irq_free | output | 1 | Free-bank interrupt |
| irq_drained | output | 1 | All-drained interrupt |

## Verification
The bench uses three kinds of fill. A hand-validated partial packet together with a zero-length packet shows that each bank keeps its own length. A 10-byte write to a bank with auto-validate off shows that writes past the bank size are dropped. A continuous 19-byte auto-validated stream shows hardware closing full banks while the short tail waits for software. Each drain starts with a refused attempt and ends with an acknowledged one, so a packet that is resent can be told apart from the next one in the queue. Isochronous runs keep auto-validate on, so any effect it still has would show up.

// File: rtl/inep_pkg.sv
package inep_pkg;

    typedef enum logic [1:0] {
        USB_IDLE = 2'd0,
        USB_ACK  = 2'd1,
        USB_NAK  = 2'd2
    } usb_evt_e;

    typedef enum int {
        IEN_FREE  = 0,
        IEN_DRAIN = 1
    } ien_bit_e;

    localparam int IEN_W = 2;

    typedef struct packed {
        logic       done;
        logic       acked;
    } usb_rpt_t;

    function automatic usb_evt_e decode_rpt(usb_rpt_t r);
        if (!r.done)
            return USB_IDLE;
        return r.acked ? USB_ACK : USB_NAK;
    endfunction

    function automatic int unsigned wrap_inc(int unsigned p, int unsigned n);
        return (p + 1 >= n) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/inep_ctl_regs.sv
module inep_ctl_regs
    import inep_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_set,
    input  logic             auto_clr,
    input  logic [IEN_W-1:0] ien_set,
    input  logic [IEN_W-1:0] ien_clr,
    output logic             auto_en,
    output logic [IEN_W-1:0] ien
);

    always_ff @(posedge clk) begin
        if (rst) begin
            auto_en <= 1'b0;
            ien     <= '0;
        end else begin
            if (auto_clr)
                auto_en <= 1'b0;
            else if (auto_set)
                auto_en <= 1'b1;
            ien <= (ien | ien_set) & ~ien_clr;
        end
    end

    // R9
    ien_clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (ien_clr != '0) |=> ((ien & $past(ien_clr)) == '0));

    // R9
    auto_clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        auto_clr |=> !auto_en);

endmodule

// File: rtl/inep_bank_store.sv
module inep_bank_store #(
    parameter int NUM_BANKS  = 3,
    parameter int BANK_BYTES = 64,
    parameter int DATA_W     = 8,
    parameter int PW         = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    parameter int IW         = $clog2(BANK_BYTES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PW-1:0]     wr_bank,
    input  logic [IW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PW-1:0]     rd_bank,
    input  logic [IW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = NUM_BANKS * BANK_BYTES;
    localparam int AW    = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     waddr;
    logic [AW-1:0]     raddr;

    always_comb begin
        waddr = AW'(int'(wr_bank) * BANK_BYTES + int'(wr_idx));
        raddr = AW'(int'(rd_bank) * BANK_BYTES + int'(rd_idx));
    end

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wr_data;
    end

    assign rd_data = mem[raddr];

endmodule

// File: rtl/inep_bank_state.sv
module inep_bank_state
    import inep_pkg::*;
#(
    parameter int NUM_BANKS  = 3,
    parameter int BANK_BYTES = 64,
    parameter int PW         = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    parameter int CW         = $clog2(BANK_BYTES + 1),
    parameter int BW         = $clog2(NUM_BANKS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          validate,
    input  logic          auto_on,
    input  logic          iso,
    input  usb_evt_e      usb_evt,
    output logic [PW-1:0] cpu_ptr,
    output logic [PW-1:0] usb_ptr,
    output logic [CW-1:0] cur_cnt,
    output logic          wr_accept,
    output logic          cur_full,
    output logic [BW-1:0] busy,
    output logic          usb_avail,
    output logic [CW-1:0] usb_len
);

    logic [NUM_BANKS-1:0] full_q;
    logic [CW-1:0]        cnt_q [NUM_BANKS];
    logic                 auto_close;
    logic                 close_bank;
    logic                 ack_go;

    always_comb begin
        cur_full   = full_q[cpu_ptr];
        cur_cnt    = cnt_q[cpu_ptr];
        usb_avail  = full_q[usb_ptr];
        usb_len    = cnt_q[usb_ptr];
        wr_accept  = wr_en && !validate && !cur_full && (cur_cnt < CW'(BANK_BYTES));
        auto_close = wr_accept && auto_on && !iso && (cur_cnt == CW'(BANK_BYTES - 1));
        close_bank = (validate && !cur_full) || auto_close;
        ack_go     = (usb_evt == USB_ACK) && usb_avail;
        busy       = '0;
        for (int i = 0; i < NUM_BANKS; i++)
            busy = busy + BW'(full_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q  <= '0;
            cpu_ptr <= '0;
            usb_ptr <= '0;
            for (int i = 0; i < NUM_BANKS; i++)
                cnt_q[i] <= '0;
        end else begin
            if (wr_accept)
                cnt_q[cpu_ptr] <= cur_cnt + CW'(1);
            if (close_bank) begin
                full_q[cpu_ptr] <= 1'b1;
                if (!iso)
                    cpu_ptr <= PW'(wrap_inc(int'(cpu_ptr), NUM_BANKS));
            end
            if (ack_go) begin
                full_q[usb_ptr] <= 1'b0;
                cnt_q[usb_ptr]  <= '0;
                if (!iso)
                    usb_ptr <= PW'(wrap_inc(int'(usb_ptr), NUM_BANKS));
            end
        end
    end

    // R2
    full_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cur_full && usb_evt != USB_ACK) |=> ($stable(cur_cnt) && $stable(cpu_ptr)));

    // R7
    nak_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (usb_evt == USB_NAK && usb_avail) |=> (usb_avail && $stable(usb_ptr) && $stable(usb_len)));

    // R4
    auto_close_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !validate && auto_on && !iso && !cur_full && usb_evt != USB_ACK
         && cur_cnt == CW'(BANK_BYTES - 1)) |=> (busy == $past(busy) + BW'(1)));

    // R11
    iso_hold_chk: assert property (@(posedge clk) disable iff (rst)
        iso |=> ($stable(cpu_ptr) && $stable(usb_ptr)));

    // R6
    busy_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy <= BW'(NUM_BANKS));

endmodule

// File: rtl/inep_txbuf.sv
module inep_txbuf
    import inep_pkg::*;
#(
    parameter int NUM_BANKS  = 3,
    parameter int BANK_BYTES = 64,
    parameter int DATA_W     = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cpu_wr_en,
    input  logic [DATA_W-1:0]                 cpu_wr_data,
    input  logic                              sw_validate,
    input  logic                              auto_set,
    input  logic                              auto_clr,
    input  logic [1:0]                        ien_set,
    input  logic [1:0]                        ien_clr,
    input  logic                              iso_mode,
    input  logic [$clog2(BANK_BYTES)-1:0]     usb_rd_idx,
    input  logic                              usb_done,
    input  logic                              usb_acked,
    output logic                              cur_bank_ready,
    output logic [$clog2(NUM_BANKS+1)-1:0]    busy_banks,
    output logic                              auto_en,
    output logic [1:0]                        ien,
    output logic                              usb_pkt_avail,
    output logic [$clog2(BANK_BYTES+1)-1:0]   usb_pkt_len,
    output logic [DATA_W-1:0]                 usb_rd_data,
    output logic                              irq_free,
    output logic                              irq_drained
);

    localparam int PW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int IW = $clog2(BANK_BYTES);
    localparam int CW = $clog2(BANK_BYTES + 1);
    localparam int BW = $clog2(NUM_BANKS + 1);

    logic [PW-1:0] cpu_ptr;
    logic [PW-1:0] usb_ptr;
    logic [CW-1:0] cur_cnt;
    logic          wr_accept;
    usb_rpt_t      rpt;
    usb_evt_e      usb_evt;

    initial begin
        if (NUM_BANKS < 1 || NUM_BANKS > 3)
            $error("NUM_BANKS must be 1 to 3");
        if (BANK_BYTES < 2)
            $error("BANK_BYTES must be at least 2");
    end

    always_comb begin
        rpt.done  = usb_done;
        rpt.acked = usb_acked;
        usb_evt   = decode_rpt(rpt);
    end

    inep_ctl_regs u_ctl (
        .clk      (clk),
        .rst      (rst),
        .auto_set (auto_set),
        .auto_clr (auto_clr),
        .ien_set  (ien_set),
        .ien_clr  (ien_clr),
        .auto_en  (auto_en),
        .ien      (ien)
    );

    inep_bank_state #(
        .NUM_BANKS  (NUM_BANKS),
        .BANK_BYTES (BANK_BYTES),
        .PW         (PW),
        .CW         (CW),
        .BW         (BW)
    ) u_state (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cpu_wr_en),
        .validate  (sw_validate),
        .auto_on   (auto_en),
        .iso       (iso_mode),
        .usb_evt   (usb_evt),
        .cpu_ptr   (cpu_ptr),
        .usb_ptr   (usb_ptr),
        .cur_cnt   (cur_cnt),
        .wr_accept (wr_accept),
        .cur_full  (cur_bank_ready),
        .busy      (busy_banks),
        .usb_avail (usb_pkt_avail),
        .usb_len   (usb_pkt_len)
    );

    inep_bank_store #(
        .NUM_BANKS  (NUM_BANKS),
        .BANK_BYTES (BANK_BYTES),
        .DATA_W     (DATA_W),
        .PW         (PW),
        .IW         (IW)
    ) u_store (
        .clk     (clk),
        .we      (wr_accept),
        .wr_bank (cpu_ptr),
        .wr_idx  (cur_cnt[IW-1:0]),
        .wr_data (cpu_wr_data),
        .rd_bank (usb_ptr),
        .rd_idx  (usb_rd_idx),
        .rd_data (usb_rd_data)
    );

    assign irq_free    = ien[IEN_FREE] && !cur_bank_ready;
    assign irq_drained = ien[IEN_DRAIN] && (busy_banks == '0);

    // R3
    validate_adds_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_validate && !cur_bank_ready && !usb_done) |=> (busy_banks == $past(busy_banks) + BW'(1)));

    // R7
    ack_frees_chk: assert property (@(posedge clk) disable iff (rst)
        (usb_done && usb_acked && usb_pkt_avail && !sw_validate && !cpu_wr_en)
        |=> (busy_banks == $past(busy_banks) - BW'(1)));

endmodule

// File: tb/test_inep_txbuf.sv
module test_inep_txbuf;

    localparam int NB = 3;
    localparam int BB = 8;

    typedef struct {
        int len;
        int base;
    } pkt_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_wr_en = 1'b0;
    logic [7:0] cpu_wr_data = '0;
    logic       sw_validate = 1'b0;
    logic       auto_set = 1'b0;
    logic       auto_clr = 1'b0;
    logic [1:0] ien_set = '0;
    logic [1:0] ien_clr = '0;
    logic       iso_mode = 1'b0;
    logic [2:0] usb_rd_idx = '0;
    logic       usb_done = 1'b0;
    logic       usb_acked = 1'b0;
    logic       cur_bank_ready;
    logic [1:0] busy_banks;
    logic       auto_en;
    logic [1:0] ien;
    logic       usb_pkt_avail;
    logic [3:0] usb_pkt_len;
    logic [7:0] usb_rd_data;
    logic       irq_free;
    logic       irq_drained;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;
    pkt_t sb_q[$];

    inep_txbuf #(.NUM_BANKS(NB), .BANK_BYTES(BB), .DATA_W(8)) i_inep_txbuf (
        .clk(clk), .rst(rst), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
        .sw_validate(sw_validate), .auto_set(auto_set), .auto_clr(auto_clr),
        .ien_set(ien_set), .ien_clr(ien_clr), .iso_mode(iso_mode),
        .usb_rd_idx(usb_rd_idx), .usb_done(usb_done), .usb_acked(usb_acked),
        .cur_bank_ready(cur_bank_ready), .busy_banks(busy_banks), .auto_en(auto_en),
        .ien(ien), .usb_pkt_avail(usb_pkt_avail), .usb_pkt_len(usb_pkt_len),
        .usb_rd_data(usb_rd_data), .irq_free(irq_free), .irq_drained(irq_drained)
    );

    always #2 clk = ~clk;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // driver: writes count bytes base, base+1, ...
    task automatic write_bytes(int base, int count);
        for (int i = 0; i < count; i++) begin
            cpu_wr_en   = 1'b1;
            cpu_wr_data = 8'(base + i);
            tick();
        end
        cpu_wr_en = 1'b0;
    endtask

    task automatic validate();
        sw_validate = 1'b1;
        tick();
        sw_validate = 1'b0;
    endtask

    task automatic expect_pkt(int len, int base);
        pkt_t p;
        p.len  = len;
        p.base = base;
        sb_q.push_back(p);
    endtask

    // monitor: one refused attempt, then compare and acknowledge
    task automatic drain_one(string req);
        pkt_t p;
        int   b;
        check({req, " avail"}, int'(usb_pkt_avail), 1);
        if (sb_q.size() == 0) begin
            check({req, " queue"}, 0, 1);
            return;
        end
        p = sb_q.pop_front();
        b = int'(busy_banks);
        usb_done = 1'b1; usb_acked = 1'b0;
        tick();
        usb_done = 1'b0;
        check("R7 nak keeps busy", int'(busy_banks), b);
        check({req, " len"}, int'(usb_pkt_len), p.len);
        for (int i = 0; i < p.len; i++) begin
            usb_rd_idx = 3'(i);
            #1;
            check({req, " data"}, int'(usb_rd_data), (p.base + i) & 8'hff);
        end
        usb_done = 1'b1; usb_acked = 1'b1;
        tick();
        usb_done = 1'b0; usb_acked = 1'b0;
        check("R7 ack frees", int'(busy_banks), b - 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1
        check("R1 busy", int'(busy_banks), 0);
        check("R1 ready", int'(cur_bank_ready), 0);
        check("R1 avail", int'(usb_pkt_avail), 0);
        check("R1 auto", int'(auto_en), 0);
        check("R1 ien", int'(ien), 0);
        check("R1 irq", int'(irq_free) + int'(irq_drained), 0);

        // R9 R10 enables
        ien_set = 2'b11; tick(); ien_set = 2'b00;
        check("R9 irq_free on", int'(irq_free), 1);
        check("R10 drained on", int'(irq_drained), 1);

        // R3 short packet, zero-length packet, R2 overfill
        write_bytes(8'h10, 5);
        check("R3 no auto valid", int'(busy_banks), 0);
        validate(); expect_pkt(5, 8'h10);
        check("R3 busy one", int'(busy_banks), 1);
        check("R6 next bank free", int'(cur_bank_ready), 0);
        check("R10 drained off", int'(irq_drained), 0);
        validate(); expect_pkt(0, 0);
        check("R3 zlp busy", int'(busy_banks), 2);
        write_bytes(8'h40, 10);
        validate(); expect_pkt(BB, 8'h40);
        check("R6 all busy", int'(busy_banks), 3);
        check("R6 cur ready", int'(cur_bank_ready), 1);
        check("R9 irq_free off", int'(irq_free), 0);
        // R2 writes and validate ignored on full bank
        write_bytes(8'hA0, 2);
        validate();
        check("R2 full ignores", int'(busy_banks), 3);
        drain_one("R8 first");
        check("R9 irq_free back", int'(irq_free), 1);
        drain_one("R8 zlp");
        drain_one("R2 overfill");
        check("R10 drained again", int'(irq_drained), 1);

        // R4 R5 auto-validate stream
        auto_set = 1'b1; tick(); auto_set = 1'b0;
        check("R9 auto on", int'(auto_en), 1);
        write_bytes(8'h80, BB);
        check("R4 auto close", int'(busy_banks), 1);
        write_bytes(8'h80 + BB, BB);
        check("R4 auto close 2", int'(busy_banks), 2);
        write_bytes(8'h80 + 2 * BB, 3);
        check("R5 short waits", int'(busy_banks), 2);
        validate();
        expect_pkt(BB, 8'h80); expect_pkt(BB, 8'h80 + BB); expect_pkt(3, 8'h80 + 2 * BB);
        check("R5 short valid", int'(busy_banks), 3);
        for (int k = 0; k < 3; k++) drain_one("R8 auto stream");

        // R9 clear wins, clear masks
        ien_set = 2'b01; ien_clr = 2'b01; tick(); ien_set = 2'b00; ien_clr = 2'b00;
        check("R9 clear wins", int'(ien), 2);
        check("R9 masked", int'(irq_free), 0);

        // R11 isochronous: auto has no effect, pointer fixed
        iso_mode = 1'b1;
        write_bytes(8'h20, BB);
        check("R11 no auto in iso", int'(busy_banks), 0);
        validate(); expect_pkt(BB, 8'h20);
        check("R11 ptr fixed", int'(cur_bank_ready), 1);
        drain_one("R11 iso drain");
        check("R11 same bank free", int'(cur_bank_ready), 0);
        write_bytes(8'h30, 2);
        validate(); expect_pkt(2, 8'h30);
        drain_one("R11 iso reuse");
        iso_mode = 1'b0;
        auto_clr = 1'b1; tick(); auto_clr = 1'b0;
        check("R9 auto off", int'(auto_en), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule